// File: doc/BRIEF.md
# Video Fetch Floating Bus Sequencer

This block follows the T-state timeline of a raster video controller and reproduces what appears on its shared video memory bus. A frame counter runs from T-state 0, which is the first T-state that begins with the interrupt request held low. The counter wraps at the end of the frame. On active display lines, a window of 128 T-states carries video fetches. The window is made of 16 groups of 8 T-states. Each group fetches four bytes in a fixed order: a bitmap byte, its attribute byte, the next bitmap byte and the next attribute byte. The last four T-states of each group are idle.

For each T-state the block presents the video memory address and the kind of fetch. When a processor reads an I/O port that nothing drives, the byte it receives is the one the video logic is fetching at that moment. If no fetch is in progress, the byte is 0xFF. The read strobe marks the final T-state of the I/O cycle, and the value present during that T-state is latched.

A late-timing select moves every fetch position one T-state later. Line length, frame height, the first active line, the number of active lines, the fetch start column and the attribute base are all parameters.

Top module: `vfb_top`

## Requirements
- R1: While `rst` is high, and in the T-state that follows its release (T-state 0), `fetch_kind` is 0 (idle) and `fetch_addr` is 0. While `rst` is high, `bus_float` is 0xFF.
- R2: T-state t of the frame lies on line t / LINE_T, column t mod LINE_T. The count wraps after LINE_T*FRAME_LINES T-states, so every frame shows the same fetch pattern.
- R3: Let p = column − FETCH_START − late, where late is 1 when `late_mode` is set and 0 otherwise. On an active line with p in 0..127, `fetch_kind` at p mod 8 = 0, 1, 2, 3 is 1 (bitmap), 2 (attribute), 3 (bitmap+1) and 4 (attribute+1). At p mod 8 = 4..7 it is 0 (idle).
- R4: On an active line, `fetch_kind` is 0 whenever p is outside 0..127.
- R5: For display row y = line − FIRST_LINE and byte column c = 2*(p/8) + (1 for the +1 fetches), a bitmap address is {y[7:6], y[2:0], y[5:3], c[4:0]}.
- R6: An attribute address is ATTR_BASE + 32*(y/8) + c, where c is the same byte column as in R5.
- R7: With `late_mode` high, every fetch position occurs one T-state later than with it low. `late_mode` may change only while `rst` is high.
- R8: When `io_rd` is high during a T-state, `bus_float` takes a new value from the next T-state on. The value is `vram_rdata` if `fetch_kind` is nonzero in that T-state, and 0xFF otherwise.
- R9: On lines outside FIRST_LINE..FIRST_LINE+ACTIVE_LINES−1, `fetch_kind` stays 0, so a read there returns 0xFF.
- R10: `bus_float` holds its value through any T-state in which `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst | input | 1 | Synchronous active-high reset to frame T-state 0 |
| late_mode | input | 1 | Selects the timing that is one T-state later |
| vram_rdata | input | 8 | Byte returned by video memory for `fetch_addr` in the same T-state |
| io_rd | input | 1 | High on the final T-state of an I/O read of an unattached port |
| fetch_addr | output | 13 | Video memory address of the current fetch, 0 when idle |
| fetch_kind | output | 3 | 0 idle, 1 bitmap, 2 attribute, 3 bitmap+1, 4 attribute+1 |
| bus_float | output | 8 | Byte latched by the last unattached port read |

## Verification
The bench compares the design with a behavioural model on every T-state of two full frames, once in normal timing and once in late timing. Reads arrive on an irregular pattern, so they fall on fetch slots, idle slots, the tail of a line and border lines.

Several kinds of error would show up at once. An error of one column at either edge of the window would let a fetch kind leak into the idle slot before or after it. If the late shift were missing, every fetch would be one T-state early. A swapped bitmap field order would scramble the addresses between rows. A latch that sampled one T-state early or late would return the neighbouring byte, or 0xFF in place of data. Running through the frame wrap exposes a counter that is off by one at the end of the frame.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
  typedef enum logic [2:0] {
    FK_IDLE = 3'd0,
    FK_BMP  = 3'd1,
    FK_ATR  = 3'd2,
    FK_BMP1 = 3'd3,
    FK_ATR1 = 3'd4
  } fetch_kind_t;

  localparam int ADDR_W   = 13;
  localparam int FETCH_T  = 128;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/vfb_tcount.sv
// Frame position counter: column within the line and line within the frame.
// The next-state values are exposed so the decode can be registered in step.
module vfb_tcount #(
  parameter int LINE_T      = 224,
  parameter int FRAME_LINES = 312,
  localparam int COL_W      = $clog2(LINE_T),
  localparam int LN_W       = $clog2(FRAME_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [COL_W-1:0] col_q,
  output logic [LN_W-1:0]  line_q,
  output logic [COL_W-1:0] col_nxt,
  output logic [LN_W-1:0]  line_nxt
);
  logic col_end, line_end;

  always_comb begin
    col_end  = (col_q == COL_W'(LINE_T - 1));
    line_end = (line_q == LN_W'(FRAME_LINES - 1));
    if (rst) begin
      col_nxt  = '0;
      line_nxt = '0;
    end else if (col_end) begin
      col_nxt  = '0;
      line_nxt = line_end ? '0 : line_q + 1'b1;
    end else begin
      col_nxt  = col_q + 1'b1;
      line_nxt = line_q;
    end
  end

  always_ff @(posedge clk) begin
    col_q  <= col_nxt;
    line_q <= line_nxt;
  end

  // R2: column wraps to zero at the end of the line
  p_col_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (col_q == COL_W'(LINE_T - 1)) |=> (col_q == '0));
  // R2: frame wraps to line zero after the last line
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    ((col_q == COL_W'(LINE_T - 1)) && (line_q == LN_W'(FRAME_LINES - 1)))
      |=> (line_q == '0));
endmodule

// File: rtl/vfb_decode.sv
// Maps a frame position onto the fetch kind and video memory address.
module vfb_decode
  import vfb_pkg::*;
#(
  parameter int LINE_T       = 224,
  parameter int FRAME_LINES  = 312,
  parameter int FIRST_LINE   = 64,
  parameter int ACTIVE_LINES = 192,
  parameter int FETCH_START  = 0,
  parameter int ATTR_BASE    = 'h1800,
  localparam int COL_W       = $clog2(LINE_T),
  localparam int LN_W        = $clog2(FRAME_LINES),
  localparam int OFF_W       = COL_W + 1
) (
  input  logic [COL_W-1:0]  col,
  input  logic [LN_W-1:0]   line,
  input  logic              late,
  output fetch_kind_t       kind,
  output logic [ADDR_W-1:0] addr
);
  logic [OFF_W-1:0] off, rel;
  logic             in_win, in_lines;
  logic [7:0]       y;
  logic [2:0]       slot;
  logic [4:0]       cbyte;
  logic [ADDR_W-1:0] bmp_addr, atr_addr;

  always_comb begin
    off      = OFF_W'(FETCH_START) + OFF_W'(late);
    rel      = {1'b0, col} - off;
    in_win   = ({1'b0, col} >= off) && (rel < OFF_W'(FETCH_T));
    in_lines = (int'(line) >= FIRST_LINE) && (int'(line) < FIRST_LINE + ACTIVE_LINES);
    y        = 8'(int'(line) - FIRST_LINE);
    slot     = rel[2:0];
    cbyte    = {rel[6:3], slot[1]};
    bmp_addr = {y[7:6], y[2:0], y[5:3], cbyte};
    atr_addr = ADDR_W'(ATTR_BASE) + {3'b000, y[7:3], cbyte};
    kind     = FK_IDLE;
    addr     = '0;
    if (in_win && in_lines && !slot[2]) begin
      unique case (slot[1:0])
        2'd0: begin kind = FK_BMP;  addr = bmp_addr; end
        2'd1: begin kind = FK_ATR;  addr = atr_addr; end
        2'd2: begin kind = FK_BMP1; addr = bmp_addr; end
        default: begin kind = FK_ATR1; addr = atr_addr; end
      endcase
    end
  end
endmodule

// File: rtl/vfb_float.sv
// Holds the byte returned by the last unattached port read.
module vfb_float
  import vfb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       io_rd,
  input  logic       fetching,
  input  logic [7:0] rdata,
  output logic [7:0] float_q
);
  always_ff @(posedge clk) begin
    if (rst)        float_q <= IDLE_BYTE;
    else if (io_rd) float_q <= fetching ? rdata : IDLE_BYTE;
  end

  // R10: no read, no change
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(float_q));
  // R8: a read on an idle slot returns the idle byte
  p_idle_read_r8: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !fetching) |=> (float_q == IDLE_BYTE));
endmodule

// File: rtl/vfb_top.sv
module vfb_top
  import vfb_pkg::*;
#(
  parameter int LINE_T       = 224,
  parameter int FRAME_LINES  = 312,
  parameter int FIRST_LINE   = 64,
  parameter int ACTIVE_LINES = 192,
  parameter int FETCH_START  = 0,
  parameter int ATTR_BASE    = 'h1800
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        late_mode,
  input  logic [7:0]  vram_rdata,
  input  logic        io_rd,
  output logic [12:0] fetch_addr,
  output logic [2:0]  fetch_kind,
  output logic [7:0]  bus_float
);
  localparam int COL_W = $clog2(LINE_T);
  localparam int LN_W  = $clog2(FRAME_LINES);

  logic [COL_W-1:0]  col_q, col_nxt;
  logic [LN_W-1:0]   line_q, line_nxt;
  fetch_kind_t       kind_nxt, kind_q;
  logic [ADDR_W-1:0] addr_nxt, addr_q;

  vfb_tcount #(.LINE_T(LINE_T), .FRAME_LINES(FRAME_LINES)) u_cnt (
    .clk(clk), .rst(rst),
    .col_q(col_q), .line_q(line_q),
    .col_nxt(col_nxt), .line_nxt(line_nxt)
  );

  vfb_decode #(
    .LINE_T(LINE_T), .FRAME_LINES(FRAME_LINES), .FIRST_LINE(FIRST_LINE),
    .ACTIVE_LINES(ACTIVE_LINES), .FETCH_START(FETCH_START), .ATTR_BASE(ATTR_BASE)
  ) u_dec (
    .col(col_nxt), .line(line_nxt), .late(late_mode),
    .kind(kind_nxt), .addr(addr_nxt)
  );

  // Registered outputs describe the T-state the counter now holds
  always_ff @(posedge clk) begin
    kind_q <= kind_nxt;
    addr_q <= addr_nxt;
  end

  vfb_float u_flt (
    .clk(clk), .rst(rst), .io_rd(io_rd),
    .fetching(kind_q != FK_IDLE), .rdata(vram_rdata),
    .float_q(bus_float)
  );

  assign fetch_kind = kind_q;
  assign fetch_addr = addr_q;

  // R3: fixed order inside a group of fetches
  p_bmp_then_atr_r3: assert property (@(posedge clk) disable iff (rst)
    (kind_q == FK_BMP) |=> (kind_q == FK_ATR));
  p_atr_then_bmp1_r3: assert property (@(posedge clk) disable iff (rst)
    (kind_q == FK_ATR) |=> (kind_q == FK_BMP1));
  p_bmp1_then_atr1_r3: assert property (@(posedge clk) disable iff (rst)
    (kind_q == FK_BMP1) |=> (kind_q == FK_ATR1));
  p_atr1_then_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (kind_q == FK_ATR1) |=> (kind_q == FK_IDLE));
  // R6: attribute fetches land in the attribute area
  p_atr_area_r6: assert property (@(posedge clk) disable iff (rst)
    ((kind_q == FK_ATR) || (kind_q == FK_ATR1)) |-> (addr_q >= ADDR_W'(ATTR_BASE)));
  // R1: idle slots drive a zero address
  p_idle_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (kind_q == FK_IDLE) |-> (addr_q == '0));
endmodule

// File: tb/vfb_top_test.sv
module vfb_top_test;
  localparam int LT  = 140;
  localparam int FL  = 20;
  localparam int FST = 3;
  localparam int ACT = 16;
  localparam int FS  = 5;
  localparam int AB  = 'h1800;
  localparam int FRAME = LT * FL;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        late_mode = 1'b0;
  logic [7:0]  vram_rdata;
  logic        io_rd = 1'b0;
  logic [12:0] fetch_addr;
  logic [2:0]  fetch_kind;
  logic [7:0]  bus_float;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h3C;
  endfunction

  assign vram_rdata = mem_byte(fetch_addr);

  vfb_top #(.LINE_T(LT), .FRAME_LINES(FL), .FIRST_LINE(FST), .ACTIVE_LINES(ACT),
            .FETCH_START(FS), .ATTR_BASE(AB)) uut (
    .clk(clk), .rst(rst), .late_mode(late_mode), .vram_rdata(vram_rdata),
    .io_rd(io_rd), .fetch_addr(fetch_addr), .fetch_kind(fetch_kind),
    .bus_float(bus_float)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model of one T-state
  task automatic model(input int t, input int late, output int kind, output int addr,
                       output string tag);
    int f, ln, col, p, slot, y, c;
    f = t % FRAME; ln = f / LT; col = f % LT; p = col - FS - late;
    kind = 0; addr = 0;
    if (ln < FST || ln >= FST + ACT) tag = "R9";
    else if (p < 0 || p >= 128) tag = "R4";
    else tag = late ? "R7" : "R3";
    if (t >= FRAME) tag = "R2";
    if (tag != "R9" && p >= 0 && p < 128 && ln >= FST && ln < FST + ACT) begin
      slot = p % 8;
      y = ln - FST;
      c = 2 * (p / 8) + ((slot == 2 || slot == 3) ? 1 : 0);
      if (slot < 4) begin
        kind = slot + 1;
        if (slot == 0 || slot == 2)
          addr = (((y >> 6) & 3) << 11) | ((y & 7) << 8) | (((y >> 3) & 7) << 5) | c;
        else
          addr = AB + 32 * (y / 8) + c;
      end
    end
  endtask

  task automatic run_mode(input int late);
    int held, ek, ea, kind_act;
    string tag;
    logic [15:0] lfsr;
    bit rd;
    lfsr = 16'hACE1;
    rst = 1'b1; io_rd = 1'b0; late_mode = late[0];
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", fetch_kind, 0);
    check("R1", fetch_addr, 0);
    check("R1", bus_float, 8'hFF);
    rst = 1'b0;
    held = 8'hFF;
    for (int t = 0; t < 2 * FRAME + 40; t++) begin
      model(t, late, ek, ea, tag);
      kind_act = fetch_kind;
      if (t == 0) tag = "R1";
      check(tag, kind_act, ek);
      if (ek == 1 || ek == 3) check("R5", fetch_addr, ea);
      else if (ek != 0) check("R6", fetch_addr, ea);
      else check(tag, fetch_addr, 0);
      check(rd ? "R8" : "R10", bus_float, held);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd = lfsr[0] & lfsr[5];
      io_rd = rd;
      if (rd) held = (ek != 0) ? int'(mem_byte(13'(ea))) : 8'hFF;
      @(negedge clk);
    end
    io_rd = 1'b0;
  endtask

  initial begin
    run_mode(0);
    run_mode(1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule